// File: doc/BRIEF.md
# Loop Detection and Training Controller

This block sits beside the instruction decoder and decides when a short loop may be handed to the back-end as a whole. It watches every decoded instruction. When it sees a PC-relative branch or jump whose target lies at or below its own address, it treats the target as the head of a loop and the branch as its tail. A loop seen for the first time is trained. On that pass the block counts the instructions in the body, which gives the resources the loop needs. From that count it derives how many copies of the body the back-end can hold.

Trained loops live in a small fully associative table keyed by start address. Each entry carries a saturating profitability score. A loop whose score is at or above the midpoint is dispatched in loop mode, and the block presents its start address, end address and unroll factor. Back-end reports then raise or lower the score. A mispredicted exit clears it. A loop that has been switched off can earn its way back one step at a time. Serialising instructions, such as system calls, memory barriers and linked load/conditional store pairs, always end loop mode and abandon training.

Top module: `lpd_top`

## Requirements
- R1: After reset, loop_mode is 0, all loop outputs are 0 and the table is empty, so the first backward branch to any target trains instead of dispatching.
- R2: A decoded branch is backward when dec_branch is 1 and dec_target <= dec_pc. When a backward branch misses the table, training starts and loop_mode stays 0. Once a trained entry has a score of 8 or more, the next backward branch to its start sets loop_mode on the following edge. From then until an exit cause arrives, loop_start equals the target and loop_end equals the branch address, and both hold steady.
- R3: N is the number of in-range instructions decoded during training, counting from the cycle after the opening branch up to and including the closing branch (pc == end, dec_branch = 1, target == start). N saturates at 63. loop_unroll = min(32 / N rounded down, 7), with a floor of 1.
- R4: A branch whose target is above its own address never starts training or dispatch.
- R5: In loop mode, a cycle with fb_valid = 1 adds 2 to the loop's 4-bit score if fb_unroll > 2 and subtracts 2 otherwise. The score saturates at 0 and 15. The cycle also ends loop mode on the next edge.
- R6: A trained loop whose score is below 8 is not dispatched.
- R7: In loop mode, mp_valid with mp_fall = 0 sets the score to 0, overriding any feedback in the same cycle. mp_valid with mp_fall = 1 leaves the score to feedback alone. Either form ends loop mode.
- R8: For a loop whose score is below 8, every second backward-branch hit adds 1 to its score.
- R9: A decoded instruction with any bit of dec_serial set has three effects. In loop mode it ends loop mode and leaves the score unchanged. During training it discards the entry being trained. In idle it keeps a branch in the same slot from acting.
- R10: During training, a decoded instruction whose pc lies outside [start, end] discards the entry and returns to idle.
- R11: The table holds 4 loops. A new allocation replaces entries in round-robin order, starting at entry 0 after reset.
- R12: Whenever loop_mode is 0, loop_start, loop_end and loop_unroll are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_pc | input | 16 | Address of the decoded instruction |
| dec_branch | input | 1 | Instruction is a PC-relative branch or jump |
| dec_target | input | 16 | Branch target address |
| dec_serial | input | 3 | Serialising kinds (call, barrier, linked pair); any set bit counts |
| fb_valid | input | 1 | Back-end report for the dispatched loop |
| fb_unroll | input | 3 | Unroll achieved by the dispatched loop |
| mp_valid | input | 1 | Misprediction inside the dispatched loop |
| mp_fall | input | 1 | The misprediction was the normal loop fall-through |
| loop_mode | output | 1 | Loop mode active |
| loop_start | output | 16 | Start address of the active loop |
| loop_end | output | 16 | Address of the closing branch of the active loop |
| loop_unroll | output | 3 | Allowed unroll factor of the active loop |

## Verification
In loop mode the score update has two sources, back-end feedback and misprediction, and both may land in the same cycle. The bench provokes this directly in two ways. It pairs a non-fall-through misprediction with favourable feedback and expects the loop to stay off afterwards. It pairs a fall-through misprediction with feedback and expects the +2 to take effect, which it detects by whether a later dispatch still happens. The random phase drives feedback, misprediction and serialising flags on independent odds, so every combination of the three reaches the exit cycle. A bench model judges each outcome cycle by cycle.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_DISP  = 2'd2
  } lpd_state_e;

  typedef enum logic [2:0] {
    SC_HOLD = 3'd0,
    SC_UP2  = 3'd1,
    SC_DN2  = 3'd2,
    SC_ZERO = 3'd3,
    SC_UP1  = 3'd4
  } sc_op_e;

  // copies of the body that fit the back-end, clamped to [1, umax]
  function automatic int unsigned unroll_of(input int unsigned res,
                                            input int unsigned slots,
                                            input int unsigned umax);
    int unsigned q;
    if (res == 0) q = umax;
    else          q = slots / res;
    if (q > umax) q = umax;
    if (q == 0)   q = 1;
    return q;
  endfunction

endpackage

// File: rtl/lpd_score.sv
module lpd_score
  import lpd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cur,
  input  sc_op_e        op,
  output logic [CW-1:0] nxt
);
  localparam logic [CW-1:0] SMAX = '1;
  localparam logic [CW-1:0] TWO  = CW'(2);
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_comb begin
    case (op)
      SC_UP2:  nxt = (cur > SMAX - TWO) ? SMAX : cur + TWO;
      SC_DN2:  nxt = (cur < TWO) ? '0 : cur - TWO;
      SC_ZERO: nxt = '0;
      SC_UP1:  nxt = (cur == SMAX) ? SMAX : cur + ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/lpd_trainer.sv
module lpd_trainer #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [RW-1:0] res_nxt
);
  localparam logic [RW-1:0] RMAX = '1;

  logic [RW-1:0] cnt;

  assign res_nxt = (cnt == RMAX) ? cnt : cnt + RW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= res_nxt;
  end
endmodule

// File: rtl/lpd_table.sv
module lpd_table #(
  parameter int AW = 16,
  parameter int NE = 4,
  parameter int CW = 4,
  parameter int RW = 6,
  localparam int IW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  // associative lookup by start address
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx,
  output logic [AW-1:0] lk_end,
  output logic [RW-1:0] lk_res,
  output logic [CW-1:0] lk_score,
  output logic          lk_stk,
  // allocation at the round-robin pointer
  input  logic          al_en,
  input  logic [AW-1:0] al_start,
  input  logic [AW-1:0] al_end,
  output logic [IW-1:0] al_idx,
  // training result
  input  logic          fn_en,
  input  logic [IW-1:0] fn_idx,
  input  logic [RW-1:0] fn_res,
  // discard
  input  logic          iv_en,
  input  logic [IW-1:0] iv_idx,
  // score read-modify-write
  input  logic          sw_en,
  input  logic [IW-1:0] sw_idx,
  input  logic [CW-1:0] sw_score,
  input  logic          sw_stk,
  output logic [CW-1:0] rd_score
);
  localparam logic [CW-1:0] INIT = {1'b1, {(CW-1){1'b0}}};

  logic          vld [NE];
  logic [AW-1:0] st  [NE];
  logic [AW-1:0] en  [NE];
  logic [RW-1:0] rs  [NE];
  logic [CW-1:0] sc  [NE];
  logic          sk  [NE];
  logic [IW-1:0] rr;

  assign al_idx   = rr;
  assign rd_score = sc[sw_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rr <= '0;
      for (int i = 0; i < NE; i++) vld[i] <= 1'b0;
    end else begin
      if (al_en) rr <= rr + IW'(1);
      for (int i = 0; i < NE; i++) begin
        if (al_en && rr == IW'(i))          vld[i] <= 1'b1;
        else if (iv_en && iv_idx == IW'(i)) vld[i] <= 1'b0;
      end
    end
  end

  // payload has no reset so it can sit in plain storage
  always_ff @(posedge clk) begin
    for (int i = 0; i < NE; i++) begin
      if (al_en && rr == IW'(i)) begin
        st[i] <= al_start;
        en[i] <= al_end;
        rs[i] <= '0;
        sc[i] <= INIT;
        sk[i] <= 1'b0;
      end else begin
        if (fn_en && fn_idx == IW'(i)) rs[i] <= fn_res;
        if (sw_en && sw_idx == IW'(i)) begin
          sc[i] <= sw_score;
          sk[i] <= sw_stk;
        end
      end
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = 0; i < NE; i++) begin
      if (vld[i] && st[i] == lk_pc) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
    end
  end

  assign lk_end   = en[lk_idx];
  assign lk_res   = rs[lk_idx];
  assign lk_score = sc[lk_idx];
  assign lk_stk   = sk[lk_idx];
endmodule

// File: rtl/lpd_top.sv
module lpd_top
  import lpd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NE    = 4,
  parameter int CW    = 4,
  parameter int RW    = 6,
  parameter int UW    = 3,
  parameter int SLOTS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_pc,
  input  logic          dec_branch,
  input  logic [AW-1:0] dec_target,
  input  logic [2:0]    dec_serial,
  input  logic          fb_valid,
  input  logic [UW-1:0] fb_unroll,
  input  logic          mp_valid,
  input  logic          mp_fall,
  output logic          loop_mode,
  output logic [AW-1:0] loop_start,
  output logic [AW-1:0] loop_end,
  output logic [UW-1:0] loop_unroll
);
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;
  localparam logic [CW-1:0] TH = {1'b1, {(CW-1){1'b0}}};
  localparam int unsigned UMAX = (1 << UW) - 1;
  localparam logic [UW-1:0] FB_MIN = UW'(2);

  lpd_state_e    state;
  logic [IW-1:0] act_idx, tr_idx;
  logic [AW-1:0] tr_start, tr_end;

  logic          lk_hit, lk_stk;
  logic [IW-1:0] lk_idx, al_idx;
  logic [AW-1:0] lk_end;
  logic [RW-1:0] lk_res, res_nxt;
  logic [CW-1:0] lk_score, rd_score, sw_score;

  logic   is_bwd, ser, in_rng, closing;
  logic   al_en, go_disp, fn_en, iv_en, sw_en, sw_stk, inc, tr_stop, dsp_exit;
  logic [IW-1:0] sw_idx;
  sc_op_e sw_op;

  assign is_bwd  = dec_valid && dec_branch && (dec_target <= dec_pc);
  assign ser     = dec_valid && (dec_serial != 3'b000);
  assign in_rng  = (dec_pc >= tr_start) && (dec_pc <= tr_end);
  assign closing = dec_branch && (dec_pc == tr_end) && (dec_target == tr_start);

  always_comb begin
    al_en    = 1'b0;
    go_disp  = 1'b0;
    fn_en    = 1'b0;
    iv_en    = 1'b0;
    sw_en    = 1'b0;
    sw_stk   = 1'b0;
    sw_op    = SC_HOLD;
    sw_idx   = lk_idx;
    inc      = 1'b0;
    tr_stop  = 1'b0;
    dsp_exit = 1'b0;
    case (state)
      ST_IDLE: begin
        if (is_bwd && !ser) begin
          if (!lk_hit)              al_en   = 1'b1;
          else if (lk_score >= TH)  go_disp = 1'b1;
          else begin
            // disabled loop: every second sighting earns one step back
            sw_en  = 1'b1;
            sw_op  = lk_stk ? SC_UP1 : SC_HOLD;
            sw_stk = !lk_stk;
          end
        end
      end
      ST_TRAIN: begin
        if (dec_valid) begin
          if (ser || !in_rng) begin
            iv_en   = 1'b1;
            tr_stop = 1'b1;
          end else begin
            inc = 1'b1;
            if (closing) begin
              fn_en   = 1'b1;
              tr_stop = 1'b1;
            end
          end
        end
      end
      ST_DISP: begin
        sw_idx   = act_idx;
        dsp_exit = fb_valid || mp_valid || ser;
        if (mp_valid && !mp_fall) begin
          sw_en = 1'b1;
          sw_op = SC_ZERO;
        end else if (fb_valid) begin
          sw_en = 1'b1;
          sw_op = (fb_unroll > FB_MIN) ? SC_UP2 : SC_DN2;
        end
      end
      default: ;
    endcase
  end

  lpd_table #(.AW(AW), .NE(NE), .CW(CW), .RW(RW)) u_tab (
    .clk(clk), .rst(rst),
    .lk_pc(dec_target), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_end(lk_end),
    .lk_res(lk_res), .lk_score(lk_score), .lk_stk(lk_stk),
    .al_en(al_en), .al_start(dec_target), .al_end(dec_pc), .al_idx(al_idx),
    .fn_en(fn_en), .fn_idx(tr_idx), .fn_res(res_nxt),
    .iv_en(iv_en), .iv_idx(tr_idx),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_score(sw_score), .sw_stk(sw_stk),
    .rd_score(rd_score)
  );

  lpd_score #(.CW(CW)) u_sc (.cur(rd_score), .op(sw_op), .nxt(sw_score));

  lpd_trainer #(.RW(RW)) u_trn (
    .clk(clk), .rst(rst), .clr(al_en), .inc(inc), .res_nxt(res_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      act_idx     <= '0;
      tr_idx      <= '0;
      tr_start    <= '0;
      tr_end      <= '0;
      loop_mode   <= 1'b0;
      loop_start  <= '0;
      loop_end    <= '0;
      loop_unroll <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go_disp) begin
            state       <= ST_DISP;
            act_idx     <= lk_idx;
            loop_mode   <= 1'b1;
            loop_start  <= dec_target;
            loop_end    <= lk_end;
            loop_unroll <= UW'(unroll_of(int'(lk_res), SLOTS, UMAX));
          end else if (al_en) begin
            state    <= ST_TRAIN;
            tr_idx   <= al_idx;
            tr_start <= dec_target;
            tr_end   <= dec_pc;
          end
        end
        ST_TRAIN: if (tr_stop) state <= ST_IDLE;
        ST_DISP: begin
          if (dsp_exit) begin
            state       <= ST_IDLE;
            loop_mode   <= 1'b0;
            loop_start  <= '0;
            loop_end    <= '0;
            loop_unroll <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpd_chk.sv
module lpd_chk #(
  parameter int AW = 16,
  parameter int UW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic [AW-1:0] dec_pc,
  input logic          dec_branch,
  input logic [AW-1:0] dec_target,
  input logic [2:0]    dec_serial,
  input logic          fb_valid,
  input logic          mp_valid,
  input logic          loop_mode,
  input logic [AW-1:0] loop_start,
  input logic [AW-1:0] loop_end,
  input logic [UW-1:0] loop_unroll
);
  logic sv;
  assign sv = dec_valid && (dec_serial != 3'b000);

  p_enter_bwd_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(loop_mode) |->
      $past(dec_valid && dec_branch && dec_target <= dec_pc && dec_serial == 3'b000));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (loop_mode && !fb_valid && !mp_valid && !sv) |=>
      (loop_mode && $stable(loop_start) && $stable(loop_end) && $stable(loop_unroll)));

  p_unroll_nz_r3: assert property (@(posedge clk) disable iff (rst)
    loop_mode |-> (loop_unroll != '0));

  p_exit_cause_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(loop_mode) && !$past(rst)) |-> $past(fb_valid || mp_valid || sv));

  p_serial_off_r9: assert property (@(posedge clk) disable iff (rst)
    (loop_mode && sv) |=> !loop_mode);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !loop_mode |-> (loop_start == '0 && loop_end == '0 && loop_unroll == '0));
endmodule

bind lpd_top lpd_chk #(.AW(AW), .UW(UW)) u_chk (.*);

// File: tb/sim_lpd_top.sv
module sim_lpd_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_valid = 1'b0, dec_branch = 1'b0;
  logic [15:0] dec_pc = '0, dec_target = '0;
  logic [2:0]  dec_serial = '0;
  logic        fb_valid = 1'b0, mp_valid = 1'b0, mp_fall = 1'b0;
  logic [2:0]  fb_unroll = '0;
  logic        loop_mode;
  logic [15:0] loop_start, loop_end;
  logic [2:0]  loop_unroll;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpd_top u0 (.*);

  // bench model state, built from the requirements
  int mv[4], mst[4], men[4], mrs[4], msc[4], mstk[4];
  int mrr, ms, mtr, mcnt, mts, mte, mact;
  int mlm, mls, mle, mlu;

  function automatic int unr(input int res);
    int q;
    q = (res == 0) ? 7 : 32 / res;
    if (q > 7) q = 7;
    if (q < 1) q = 1;
    return q;
  endfunction

  task automatic model_step();
    int h;
    bit bwd, sr;
    if (rst) begin
      for (int i = 0; i < 4; i++) mv[i] = 0;
      mrr = 0; ms = 0; mtr = 0; mcnt = 0; mact = 0;
      mlm = 0; mls = 0; mle = 0; mlu = 0;
      return;
    end
    bwd = dec_valid && dec_branch && (dec_target <= dec_pc);
    sr  = dec_valid && (dec_serial != 0);
    case (ms)
      0: if (bwd && !sr) begin
        h = -1;
        for (int i = 0; i < 4; i++) if (mv[i] != 0 && mst[i] == int'(dec_target)) h = i;
        if (h >= 0) begin
          if (msc[h] >= 8) begin
            ms = 2; mact = h; mlm = 1; mls = dec_target; mle = men[h]; mlu = unr(mrs[h]);
          end else if (mstk[h] != 0) begin
            msc[h] = (msc[h] < 15) ? msc[h] + 1 : 15; mstk[h] = 0;
          end else mstk[h] = 1;
        end else begin
          mv[mrr] = 1; mst[mrr] = dec_target; men[mrr] = dec_pc;
          mrs[mrr] = 0; msc[mrr] = 8; mstk[mrr] = 0;
          mtr = mrr; mrr = (mrr + 1) % 4; mcnt = 0;
          mts = dec_target; mte = dec_pc; ms = 1;
        end
      end
      1: if (dec_valid) begin
        if (sr || int'(dec_pc) < mts || int'(dec_pc) > mte) begin
          mv[mtr] = 0; ms = 0;
        end else begin
          mcnt = (mcnt < 63) ? mcnt + 1 : 63;
          if (dec_branch && int'(dec_pc) == mte && int'(dec_target) == mts) begin
            mrs[mtr] = mcnt; ms = 0;
          end
        end
      end
      default: begin
        if (mp_valid && !mp_fall) begin msc[mact] = 0; mstk[mact] = 0; end
        else if (fb_valid) begin
          if (fb_unroll > 2) msc[mact] = (msc[mact] > 13) ? 15 : msc[mact] + 2;
          else               msc[mact] = (msc[mact] < 2) ? 0 : msc[mact] - 2;
          mstk[mact] = 0;
        end
        if (fb_valid || mp_valid || sr) begin
          ms = 0; mlm = 0; mls = 0; mle = 0; mlu = 0;
        end
      end
    endcase
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2/R12 model loop_mode", int'(loop_mode), mlm);
    chk("R2/R12 model loop_start", int'(loop_start), mls);
    chk("R2/R12 model loop_end", int'(loop_end), mle);
    chk("R3/R12 model loop_unroll", int'(loop_unroll), mlu);
  endtask

  task automatic drv(input bit v, input int pc, input bit br, input int tgt,
                     input int sr, input bit fv, input int fu, input bit mpv, input bit mf);
    dec_valid = v; dec_pc = 16'(pc); dec_branch = br; dec_target = 16'(tgt);
    dec_serial = 3'(sr); fb_valid = fv; fb_unroll = 3'(fu); mp_valid = mpv; mp_fall = mf;
    cyc();
    dec_valid = 0; dec_branch = 0; dec_serial = 0; fb_valid = 0; mp_valid = 0; mp_fall = 0;
  endtask

  task automatic ins(input int pc);            drv(1, pc, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic hit(input int s, input int e); drv(1, e, 1, s, 0, 0, 0, 0, 0); endtask
  task automatic fb(input int u);               drv(0, 0, 0, 0, 0, 1, u, 0, 0); endtask
  task automatic train(input int s, input int e);
    hit(s, e);
    for (int p = s; p <= e; p++) drv(1, p, p == e, s, 0, 0, 0, 0, 0);
  endtask
  task automatic do_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
  endtask

  initial begin
    int cur, pc, s, e, dummy;
    dummy = $urandom(32'd4242);
    do_reset();
    chk("R1 loop_mode", loop_mode, 0);
    chk("R1 outputs", int'(loop_start) + int'(loop_end) + int'(loop_unroll), 0);

    train(16'h10, 16'h13);
    chk("R2 no mode while training", loop_mode, 0);
    drv(1, 16'h05, 1, 16'h10, 0, 0, 0, 0, 0);
    chk("R4 forward branch ignored", loop_mode, 0);
    hit(16'h10, 16'h13);
    chk("R2 enter", loop_mode, 1);
    chk("R2 start", loop_start, 16'h10);
    chk("R2 end", loop_end, 16'h13);
    chk("R3 unroll 4 instr", loop_unroll, 7);
    fb(3);
    chk("R5 exit on feedback", loop_mode, 0);
    chk("R12 start zero", loop_start, 0);
    hit(16'h10, 16'h13); fb(1);          // 10 -> 8
    hit(16'h10, 16'h13);
    chk("R5 score 8 dispatches", loop_mode, 1);
    fb(2);                               // 8 -> 6
    hit(16'h10, 16'h13);
    chk("R6 score 6 no dispatch", loop_mode, 0);
    hit(16'h10, 16'h13);                 // 7
    hit(16'h10, 16'h13);
    hit(16'h10, 16'h13);                 // 8
    chk("R8 still off before recovery hit", loop_mode, 0);
    hit(16'h10, 16'h13);
    chk("R8 recovered to 8", loop_mode, 1);
    drv(0, 0, 0, 0, 0, 1, 5, 1, 0);      // mispredict beats feedback
    chk("R7 exit", loop_mode, 0);
    hit(16'h10, 16'h13);
    chk("R7 score cleared", loop_mode, 0);

    train(16'h40, 16'h47);
    hit(16'h40, 16'h47);
    chk("R3 unroll 8 instr", loop_unroll, 4);
    drv(0, 0, 0, 0, 0, 1, 3, 1, 1);      // fall-through plus good feedback -> 10
    chk("R7 fall-through exit", loop_mode, 0);
    hit(16'h40, 16'h47); fb(0);          // 8
    hit(16'h40, 16'h47);
    chk("R7 fall-through kept feedback", loop_mode, 1);
    drv(1, 16'h41, 0, 0, 3'b010, 0, 0, 0, 0);
    chk("R9 serial ends loop mode", loop_mode, 0);
    hit(16'h40, 16'h47);
    chk("R9 score untouched", loop_mode, 1);
    fb(3);

    hit(16'h80, 16'h82);
    drv(1, 16'h80, 0, 0, 3'b001, 0, 0, 0, 0);
    hit(16'h80, 16'h82);
    chk("R9 training discarded", loop_mode, 0);
    ins(16'h80); ins(16'h81); hit(16'h80, 16'h82);
    hit(16'h80, 16'h82);
    chk("R9 retrained loop dispatches", loop_mode, 1);
    fb(3);
    drv(1, 16'h90, 1, 16'h80, 3'b100, 0, 0, 0, 0);
    chk("R9 serial blocks idle branch", loop_mode, 0);

    hit(16'hA0, 16'hA1);
    ins(16'h30);
    ins(16'hA0); hit(16'hA0, 16'hA1);
    hit(16'hA0, 16'hA1);
    chk("R10 out-of-range aborts", loop_mode, 0);
    hit(16'hA0, 16'hA1);
    chk("R10 retrained", loop_mode, 1);
    chk("R3 unroll 2 instr", loop_unroll, 7);
    fb(3);

    do_reset();
    chk("R1 after second reset", loop_mode, 0);
    for (int k = 0; k < 5; k++) train(16'h200 + 16 * k, 16'h201 + 16 * k);
    hit(16'h210, 16'h211);
    chk("R11 second entry kept", loop_mode, 1);
    fb(3);
    hit(16'h200, 16'h201);
    chk("R11 oldest entry replaced", loop_mode, 0);

    // constrained random walk over six loops of lengths 2..17
    cur = 0; pc = 16'h400;
    for (int n = 0; n < 4000; n++) begin
      bit v, br;
      int tgt;
      s = 16'h400 + cur * 16'h40; e = s + 1 + 3 * cur;
      v = ($urandom % 8) != 0;
      br = v && (pc == e); tgt = s;
      if (v && !br && ($urandom % 10) == 0) begin br = 1; tgt = pc + 5; end
      drv(v, pc, br, tgt, (($urandom % 40) == 0) ? 1 + $urandom % 7 : 0,
          ($urandom % 5) == 0, $urandom % 8, ($urandom % 9) == 0, $urandom % 2);
      if (v) begin
        if (pc == e || ($urandom % 40) == 0) begin
          if (($urandom % 6) == 0 || pc != e) cur = $urandom % 6;
          pc = 16'h400 + cur * 16'h40;
        end else pc = pc + 1;
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule